// File: doc/BRIEF.md
# Port Controller Register File

This block is the control and status register file of a USB Type-C port controller, as a host sees it over a simple byte-transaction bus. The host presents one whole transaction per cycle: an address byte, a count of write data bytes with up to two data bytes, and a count of bytes it wants read back. One cycle later the block answers with a response strobe, the read data and an error flag.

The registers are one or two bytes wide and take fixed reset defaults. The role-control and message-header defaults are derived from the power-role field of the capability register's reset value. The alert register is cleared by writing ones to it. Status bits can also be set and cleared from the hardware side. An active-low interrupt follows the masked alert register. A transaction whose byte counts do not match the register width, or that addresses an unmapped location, is refused: it changes nothing and returns zero data.

Top module: `tcpc_regfile`

## Requirements
- R1: After reset these registers read as follows: address 18 (Type-C revision, 2 bytes) reads 0x0013, 19 (PD revision, 2 bytes) reads 0x3012, 20 (interface revision, 2 bytes) reads 0x2011, 1 (alert mask, 2 bytes) reads 0x7FFF, 2 (power status mask) reads 0xFF, 3 (fault status mask) reads 0xFF, 4 (extended status mask) reads 0x01 and 5 (extended alert mask) reads 0x07.
- R2: After reset address 11 (fault status) reads 0x80 and address 6 (power control) reads 0x60. Every register not named in R1 or R3 resets to zero, including 17 (command), 0 (alert) and 14 (port control).
- R3: Address 9 (capability, 2 bytes) resets to parameter DEVCAP_RESET. Its bits [3:1] hold a power-role code that sets the reset values of address 7 (role control) and address 8 (header info). Code 1 (source only) gives 0x05 and 0x0D. Codes 4, 5 and 6 (dual role) give 0x4A when DBG_ACC_IND=1 and 0x0F when it is 0, each with 0x04. Codes 0, 2, 3 and 7 give 0x0A and 0x04.
- R4: Multi-byte values are ordered least significant byte first. The first data byte is txn_wdata[7:0] and the second is txn_wdata[15:8]. On a read, the first byte returned is rsp_data[7:0]. A one-byte write uses only txn_wdata[7:0].
- R5: A write is accepted only when txn_wlen equals the register width and txn_rlen is 0. The register is updated at the clock edge that samples txn_valid. rsp_valid is high exactly in the cycle after txn_valid.
- R6: A read is accepted only when txn_rlen equals the register width and txn_wlen is 0. It returns the register value, with upper unused bytes zero.
- R7: Any other combination of counts is refused. This includes a mix of write and read counts, and both counts being zero. A refused transaction raises rsp_err with rsp_data 0 and modifies no register.
- R8: An address of 21 or above raises rsp_err and returns rsp_data 0.
- R9: A host write to the alert register (address 0) clears each bit written as 1 and keeps every bit written as 0.
- R10: hw_alert_set sets alert bits in the same edge. When it coincides with a host clear of the same bit, the bit stays set.
- R11: hw_pwr_set/hw_pwr_clr act on power status (address 10) and hw_flt_set/hw_flt_clr act on fault status (address 11). A set beats a clear of the same bit, and both override a host write in the same cycle.
- R12: irq_n is low exactly when the alert register ANDed with the alert mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | One transaction presented this cycle |
| txn_addr | input | 8 | Register address byte |
| txn_wlen | input | LEN_W | Number of write data bytes after the address |
| txn_wdata | input | 16 | Write data, first byte in [7:0] |
| txn_rlen | input | LEN_W | Number of bytes requested for reading |
| hw_alert_set | input | 16 | Hardware set of alert bits |
| hw_pwr_set | input | 8 | Hardware set of power status bits |
| hw_pwr_clr | input | 8 | Hardware clear of power status bits |
| hw_flt_set | input | 8 | Hardware set of fault status bits |
| hw_flt_clr | input | 8 | Hardware clear of fault status bits |
| rsp_valid | output | 1 | Response for the previous cycle's transaction |
| rsp_data | output | 16 | Read data, first byte in [7:0] |
| rsp_err | output | 1 | Transaction refused |
| irq_n | output | 1 | Active-low interrupt from masked alerts |

## Verification
The transaction path is exercised with reads of every width-distinct reset value, with well-formed one- and two-byte writes, and with malformed count combinations. The malformed cases are a short read, an over-long write, write and read counts mixed, both counts zero, and unmapped addresses. Each refused case is followed by a read-back that shows the register unchanged. A one-byte write with a filled upper data byte shows the byte ordering. Separate instances with other capability codes show the role-dependent defaults. Alert and status updates are tried with the host alone, the hardware alone, and both in one cycle, which tells the clear-on-one rule apart from plain overwrite and shows which side wins. The interrupt is checked with alerts outside and inside the mask.

// File: rtl/tcpc_rf_pkg.sv
// Shared constants and reset-value functions for the port controller
// register file. Assumes the register index equals its byte address.
package tcpc_rf_pkg;

    localparam int NREG   = 21;
    localparam int IDX_W  = $clog2(NREG);
    localparam int DATA_W = 16;

    localparam int IDX_ALERT  = 0;
    localparam int IDX_AMASK  = 1;
    localparam int IDX_PSMASK = 2;
    localparam int IDX_FSMASK = 3;
    localparam int IDX_XSMASK = 4;
    localparam int IDX_AXMASK = 5;
    localparam int IDX_PCTRL  = 6;
    localparam int IDX_ROLE   = 7;
    localparam int IDX_HDR    = 8;
    localparam int IDX_DEVCAP = 9;
    localparam int IDX_PSTAT  = 10;
    localparam int IDX_FSTAT  = 11;
    localparam int IDX_TCREV  = 18;
    localparam int IDX_PDREV  = 19;
    localparam int IDX_IFREV  = 20;

    // Width in bytes of the register at a given index.
    function automatic int reg_bytes(input int idx);
        case (idx)
            IDX_ALERT, IDX_AMASK, IDX_DEVCAP,
            IDX_TCREV, IDX_PDREV, IDX_IFREV: return 2;
            default:                         return 1;
        endcase
    endfunction

    // Role control default from the capability power-role code.
    function automatic logic [7:0] role_default(input logic [2:0] role, input bit dbg_ind);
        case (role)
            3'd1:             return 8'h05;
            3'd4, 3'd5, 3'd6: return dbg_ind ? 8'h4A : 8'h0F;
            default:          return 8'h0A;
        endcase
    endfunction

    // Message header info default from the capability power-role code.
    function automatic logic [7:0] hdr_default(input logic [2:0] role);
        return (role == 3'd1) ? 8'h0D : 8'h04;
    endfunction

    // Complete reset value of one register.
    function automatic logic [DATA_W-1:0] reg_reset(input int idx,
                                                    input logic [DATA_W-1:0] devcap,
                                                    input bit dbg_ind);
        case (idx)
            IDX_AMASK:  return 16'h7FFF;
            IDX_PSMASK: return 16'h00FF;
            IDX_FSMASK: return 16'h00FF;
            IDX_XSMASK: return 16'h0001;
            IDX_AXMASK: return 16'h0007;
            IDX_PCTRL:  return 16'h0060;
            IDX_ROLE:   return {8'h00, role_default(devcap[3:1], dbg_ind)};
            IDX_HDR:    return {8'h00, hdr_default(devcap[3:1])};
            IDX_DEVCAP: return devcap;
            IDX_FSTAT:  return 16'h0080;
            IDX_TCREV:  return 16'h0013;
            IDX_PDREV:  return 16'h3012;
            IDX_IFREV:  return 16'h2011;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/tcpc_rf_decode.sv
// Address and length decoder. Maps an address byte to a register index,
// and qualifies the transaction as a legal write or a legal read by
// comparing the byte counts with the register width. Purely combinational.
module tcpc_rf_decode
    import tcpc_rf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  wlen,
    input  logic [LEN_W-1:0]  rlen,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_ok,
    output logic              rd_ok
);
    logic known;
    int   width;

    // Look up the index and width, then qualify the byte counts.
    always_comb begin
        known = (int'(addr) < NREG);
        idx   = known ? addr[IDX_W-1:0] : '0;
        width = known ? reg_bytes(int'(addr)) : 0;
        wr_ok = known && (rlen == '0) && (wlen == LEN_W'(width));
        rd_ok = known && (wlen == '0) && (rlen == LEN_W'(width));
    end
endmodule

// File: rtl/tcpc_rf_store.sv
// Register storage. One flop group per register, each generated with its
// own reset value and update rule: clear-on-one for the alert register,
// hardware set/clear overrides for the two status registers, and plain
// overwrite for the rest. Assumes wr_en is already qualified.
module tcpc_rf_store
    import tcpc_rf_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEVCAP_RESET = 16'h001D,
    parameter bit                DBG_ACC_IND  = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [DATA_W-1:0]            hw_alert_set,
    input  logic [7:0]                   hw_pwr_set,
    input  logic [7:0]                   hw_pwr_clr,
    input  logic [7:0]                   hw_flt_set,
    input  logic [7:0]                   hw_flt_clr,
    output logic [NREG-1:0][DATA_W-1:0]  regs
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DATA_W-1:0] RST  = reg_reset(i, DEVCAP_RESET, DBG_ACC_IND);
        localparam logic [DATA_W-1:0] KEEP = (reg_bytes(i) == 2) ? 16'hFFFF : 16'h00FF;
        logic [DATA_W-1:0] nxt;
        logic              hit;

        // Compute the next value: host access first, hardware on top.
        always_comb begin
            hit = wr_en && (wr_idx == IDX_W'(i));
            nxt = regs[i];
            if (hit) begin
                if (i == IDX_ALERT) nxt = regs[i] & ~wr_data;
                else                nxt = wr_data & KEEP;
            end
            if (i == IDX_ALERT) nxt = nxt | hw_alert_set;
            if (i == IDX_PSTAT) nxt = (nxt & ~{8'h00, hw_pwr_clr}) | {8'h00, hw_pwr_set};
            if (i == IDX_FSTAT) nxt = (nxt & ~{8'h00, hw_flt_clr}) | {8'h00, hw_flt_set};
        end

        // Hold the register, loading its default under reset.
        always_ff @(posedge clk) begin
            if (!rst_n) regs[i] <= RST;
            else        regs[i] <= nxt;
        end
    end
endmodule

// File: rtl/tcpc_regfile.sv
// Top of the port controller register file. Accepts one whole byte
// transaction per cycle, answers one cycle later, and drives an
// active-low interrupt from the masked alert register.
// Assumes the host waits for nothing: every transaction gets a response.
module tcpc_regfile
    import tcpc_rf_pkg::*;
#(
    parameter int                LEN_W        = 8,
    parameter logic [DATA_W-1:0] DEVCAP_RESET = 16'h001D,
    parameter bit                DBG_ACC_IND  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_valid,
    input  logic [7:0]        txn_addr,
    input  logic [LEN_W-1:0]  txn_wlen,
    input  logic [DATA_W-1:0] txn_wdata,
    input  logic [LEN_W-1:0]  txn_rlen,
    input  logic [DATA_W-1:0] hw_alert_set,
    input  logic [7:0]        hw_pwr_set,
    input  logic [7:0]        hw_pwr_clr,
    input  logic [7:0]        hw_flt_set,
    input  logic [7:0]        hw_flt_clr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              irq_n
);
    logic [IDX_W-1:0]            idx;
    logic                        wr_ok;
    logic                        rd_ok;
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]           alert_val;
    logic [DATA_W-1:0]           amask_val;

    tcpc_rf_decode #(.ADDR_W(8), .LEN_W(LEN_W)) u_dec (
        .addr  (txn_addr),
        .wlen  (txn_wlen),
        .rlen  (txn_rlen),
        .idx   (idx),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok)
    );

    tcpc_rf_store #(.DEVCAP_RESET(DEVCAP_RESET), .DBG_ACC_IND(DBG_ACC_IND)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (txn_valid && wr_ok),
        .wr_idx       (idx),
        .wr_data      (txn_wdata),
        .hw_alert_set (hw_alert_set),
        .hw_pwr_set   (hw_pwr_set),
        .hw_pwr_clr   (hw_pwr_clr),
        .hw_flt_set   (hw_flt_set),
        .hw_flt_clr   (hw_flt_clr),
        .regs         (regs)
    );

    assign alert_val = regs[IDX_ALERT];
    assign amask_val = regs[IDX_AMASK];

    // Interrupt is asserted while any unmasked alert bit is set.
    assign irq_n = ~|(alert_val & amask_val);

    // Register the response for the transaction sampled at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= txn_valid;
            rsp_err   <= txn_valid && !(wr_ok || rd_ok);
            rsp_data  <= (txn_valid && rd_ok) ? regs[idx] : '0;
        end
    end
endmodule

// File: rtl/tcpc_rf_chk.sv
// Assertion checker for tcpc_regfile, bound to every instance of it.
// Observes ports plus the alert register value.
module tcpc_rf_chk
    import tcpc_rf_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_valid,
    input logic [7:0]        txn_addr,
    input logic [LEN_W-1:0]  txn_wlen,
    input logic [LEN_W-1:0]  txn_rlen,
    input logic [DATA_W-1:0] hw_alert_set,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_err,
    input logic              irq_n,
    input logic [DATA_W-1:0] alert_val
);
    p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> rsp_valid);

    p_no_idle_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !rsp_valid);

    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_data == '0));

    p_len_mix_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_wlen != '0 && txn_rlen != '0) |=> rsp_err);

    p_unknown_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && int'(txn_addr) >= NREG) |=> rsp_err);

    p_hwset_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_alert_set) |=> ((alert_val & $past(hw_alert_set)) == $past(hw_alert_set)));

    p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (alert_val != '0));
endmodule

bind tcpc_regfile tcpc_rf_chk #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .txn_valid    (txn_valid),
    .txn_addr     (txn_addr),
    .txn_wlen     (txn_wlen),
    .txn_rlen     (txn_rlen),
    .hw_alert_set (hw_alert_set),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err),
    .irq_n        (irq_n),
    .alert_val    (alert_val)
);

// File: tb/tcpc_regfile_tb.sv
// Bench for tcpc_regfile: a vector table walked by one loop, then
// directed tests for alert, status, interrupt and role-dependent defaults.
module tcpc_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_valid = 1'b0;
    logic [7:0]  txn_addr = '0;
    logic [7:0]  txn_wlen = '0;
    logic [15:0] txn_wdata = '0;
    logic [7:0]  txn_rlen = '0;
    logic [15:0] hw_alert_set = '0;
    logic [7:0]  hw_pwr_set = '0, hw_pwr_clr = '0, hw_flt_set = '0, hw_flt_clr = '0;

    logic        rv [4];
    logic [15:0] rd [4];
    logic        re [4];
    logic        iq [4];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    // Instance 0: default (dual role, debug indication), 1: source only,
    // 2: sink only, 3: dual role without debug indication.
    tcpc_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_wlen(txn_wlen), .txn_wdata(txn_wdata), .txn_rlen(txn_rlen),
        .hw_alert_set(hw_alert_set), .hw_pwr_set(hw_pwr_set), .hw_pwr_clr(hw_pwr_clr),
        .hw_flt_set(hw_flt_set), .hw_flt_clr(hw_flt_clr),
        .rsp_valid(rv[0]), .rsp_data(rd[0]), .rsp_err(re[0]), .irq_n(iq[0]));

    tcpc_regfile #(.DEVCAP_RESET(16'h0003)) dut_src (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_wlen(txn_wlen), .txn_wdata(txn_wdata), .txn_rlen(txn_rlen),
        .hw_alert_set(hw_alert_set), .hw_pwr_set(hw_pwr_set), .hw_pwr_clr(hw_pwr_clr),
        .hw_flt_set(hw_flt_set), .hw_flt_clr(hw_flt_clr),
        .rsp_valid(rv[1]), .rsp_data(rd[1]), .rsp_err(re[1]), .irq_n(iq[1]));

    tcpc_regfile #(.DEVCAP_RESET(16'h0014)) dut_snk (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_wlen(txn_wlen), .txn_wdata(txn_wdata), .txn_rlen(txn_rlen),
        .hw_alert_set(hw_alert_set), .hw_pwr_set(hw_pwr_set), .hw_pwr_clr(hw_pwr_clr),
        .hw_flt_set(hw_flt_set), .hw_flt_clr(hw_flt_clr),
        .rsp_valid(rv[2]), .rsp_data(rd[2]), .rsp_err(re[2]), .irq_n(iq[2]));

    tcpc_regfile #(.DEVCAP_RESET(16'h0008), .DBG_ACC_IND(1'b0)) dut_nodbg (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_wlen(txn_wlen), .txn_wdata(txn_wdata), .txn_rlen(txn_rlen),
        .hw_alert_set(hw_alert_set), .hw_pwr_set(hw_pwr_set), .hw_pwr_clr(hw_pwr_clr),
        .hw_flt_set(hw_flt_set), .hw_flt_clr(hw_flt_clr),
        .rsp_valid(rv[3]), .rsp_data(rd[3]), .rsp_err(re[3]), .irq_n(iq[3]));

    typedef struct packed {
        logic [7:0]  addr;
        logic [7:0]  wl;
        logic [15:0] wd;
        logic [7:0]  rl;
        logic        err;
        logic [15:0] exp;
        logic [3:0]  rq;
    } vec_t;

    // Table walk order matters: later reads see earlier writes.
    localparam vec_t VEC [24] = '{
        '{8'd18,  8'd0, 16'h0000, 8'd2, 1'b0, 16'h0013, 4'd1},
        '{8'd19,  8'd0, 16'h0000, 8'd2, 1'b0, 16'h3012, 4'd1},
        '{8'd20,  8'd0, 16'h0000, 8'd2, 1'b0, 16'h2011, 4'd1},
        '{8'd1,   8'd0, 16'h0000, 8'd2, 1'b0, 16'h7FFF, 4'd1},
        '{8'd5,   8'd0, 16'h0000, 8'd1, 1'b0, 16'h0007, 4'd1},
        '{8'd4,   8'd0, 16'h0000, 8'd1, 1'b0, 16'h0001, 4'd1},
        '{8'd2,   8'd0, 16'h0000, 8'd1, 1'b0, 16'h00FF, 4'd1},
        '{8'd11,  8'd0, 16'h0000, 8'd1, 1'b0, 16'h0080, 4'd2},
        '{8'd6,   8'd0, 16'h0000, 8'd1, 1'b0, 16'h0060, 4'd2},
        '{8'd7,   8'd0, 16'h0000, 8'd1, 1'b0, 16'h004A, 4'd3},
        '{8'd8,   8'd0, 16'h0000, 8'd1, 1'b0, 16'h0004, 4'd3},
        '{8'd9,   8'd0, 16'h0000, 8'd2, 1'b0, 16'h001D, 4'd6},
        '{8'd14,  8'd1, 16'h77A5, 8'd0, 1'b0, 16'h0000, 4'd5},
        '{8'd14,  8'd0, 16'h0000, 8'd1, 1'b0, 16'h00A5, 4'd4},
        '{8'd1,   8'd2, 16'h1234, 8'd0, 1'b0, 16'h0000, 4'd5},
        '{8'd1,   8'd0, 16'h0000, 8'd2, 1'b0, 16'h1234, 4'd4},
        '{8'd1,   8'd0, 16'h0000, 8'd1, 1'b1, 16'h0000, 4'd7},
        '{8'd14,  8'd2, 16'h0033, 8'd0, 1'b1, 16'h0000, 4'd7},
        '{8'd14,  8'd0, 16'h0000, 8'd1, 1'b0, 16'h00A5, 4'd7},
        '{8'd14,  8'd1, 16'h0011, 8'd1, 1'b1, 16'h0000, 4'd7},
        '{8'd64,  8'd0, 16'h0000, 8'd1, 1'b1, 16'h0000, 4'd8},
        '{8'd255, 8'd1, 16'h0022, 8'd0, 1'b1, 16'h0000, 4'd8},
        '{8'd14,  8'd0, 16'h0000, 8'd0, 1'b1, 16'h0000, 4'd7},
        '{8'd17,  8'd0, 16'h0000, 8'd1, 1'b0, 16'h0000, 4'd2}
    };

    task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", rq, what, act, exp);
        end
    endtask

    // Present one transaction (optionally with hardware pulses) for one cycle;
    // returns at the next falling edge, where the response is valid.
    task automatic txn(input logic [7:0] a, input logic [7:0] wl, input logic [15:0] wd,
                       input logic [7:0] rl, input logic [15:0] aset = '0,
                       input logic [7:0] fset = '0, input logic [7:0] fclr = '0);
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = a; txn_wlen = wl; txn_wdata = wd; txn_rlen = rl;
        hw_alert_set = aset; hw_flt_set = fset; hw_flt_clr = fclr;
        @(negedge clk);
        txn_valid = 1'b0; txn_wlen = '0; txn_rlen = '0; txn_wdata = '0;
        hw_alert_set = '0; hw_flt_set = '0; hw_flt_clr = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] rl, input logic [15:0] exp, input string rq);
        txn(a, 8'd0, 16'h0, rl);
        chk(rq, "read data", rd[0], exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: no response without a transaction; R12: no interrupt at reset
        chk("R5", "idle rsp_valid", {15'h0, rv[0]}, 16'h0000);
        chk("R12", "reset irq_n", {15'h0, iq[0]}, 16'h0001);

        // R3: role-dependent defaults on the other instances
        txn(8'd7, 8'd0, 16'h0, 8'd1);
        chk("R3", "role src", rd[1], 16'h0005);
        chk("R3", "role snk", rd[2], 16'h000A);
        chk("R3", "role drp nodbg", rd[3], 16'h000F);
        txn(8'd8, 8'd0, 16'h0, 8'd1);
        chk("R3", "hdr src", rd[1], 16'h000D);
        chk("R3", "hdr snk", rd[2], 16'h0004);
        chk("R3", "hdr drp nodbg", rd[3], 16'h0004);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
        foreach (VEC[k]) begin
            txn(VEC[k].addr, VEC[k].wl, VEC[k].wd, VEC[k].rl);
            chk($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d valid", k), {15'h0, rv[0]}, 16'h0001);
            chk($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d err", k), {15'h0, re[0]}, {15'h0, VEC[k].err});
            chk($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d data", k), rd[0], VEC[k].exp);
        end
        @(negedge clk);
        chk("R5", "single-cycle rsp_valid", {15'h0, rv[0]}, 16'h0000);

        // R10: hardware sets alert bits; mask 0x1234 excludes them (R12)
        txn(8'd0, 8'd0, 16'h0, 8'd0, 16'h8041);
        rd_chk(8'd0, 8'd2, 16'h8041, "R10");
        chk("R12", "masked-out irq_n", {15'h0, iq[0]}, 16'h0001);
        txn(8'd1, 8'd2, 16'h0001, 8'd0);
        chk("R12", "unmasked irq_n", {15'h0, iq[0]}, 16'h0000);
        // R9: clear-on-one
        txn(8'd0, 8'd2, 16'h0040, 8'd0);
        rd_chk(8'd0, 8'd2, 16'h8001, "R9");
        chk("R12", "irq_n still low", {15'h0, iq[0]}, 16'h0000);
        txn(8'd0, 8'd2, 16'h0001, 8'd0);
        chk("R12", "irq_n released", {15'h0, iq[0]}, 16'h0001);
        rd_chk(8'd0, 8'd2, 16'h8000, "R9");
        // R10: host clear and hardware set of the same bit together
        txn(8'd0, 8'd2, 16'h8000, 8'd0, 16'h8000);
        rd_chk(8'd0, 8'd2, 16'h8000, "R10");

        // R11: status set/clear ports
        txn(8'd11, 8'd0, 16'h0, 8'd0, 16'h0, 8'h00, 8'h80);
        rd_chk(8'd11, 8'd1, 16'h0000, "R11");
        @(negedge clk);
        hw_pwr_set = 8'h05; hw_pwr_clr = 8'h04;
        @(negedge clk);
        hw_pwr_set = 8'h00; hw_pwr_clr = 8'h00;
        rd_chk(8'd10, 8'd1, 16'h0005, "R11");
        txn(8'd11, 8'd1, 16'h0012, 8'd0, 16'h0, 8'h01, 8'h00);
        rd_chk(8'd11, 8'd1, 16'h0013, "R11");
        txn(8'd11, 8'd1, 16'h0012, 8'd0, 16'h0, 8'h00, 8'h02);
        rd_chk(8'd11, 8'd1, 16'h0010, "R11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule